// File: doc/BRIEF.md
# Register Locator Table Scanner

This block walks a configuration-space structure that lists register blocks and finds the entry that describes the memory-device register block. A single `start` pulse launches the scan at a byte address `base_addr`. The block then issues 32-bit reads on a simple request/acknowledge read port. It first fetches the header dword that holds the structure length and derives the number of 8-byte entries from it. It then steps through the entries and stops at the first one whose block identifier marks a memory device.

For the selected entry the block reports three things: the BAR index, the 64-bit block offset, and whether the caller-supplied length of that BAR is too small to hold the offset. A one-cycle `done` pulse closes every scan, and `found` tells whether a match was seen. The results hold until the next scan starts.

The entry count is computed from the structure length once, before any entry is read. The scan therefore never reads an entry slot beyond the end of the structure.

Top module: `regloc_scan`

## Requirements
- R1: After `start` in idle, the first read is the dword at `base_addr + 4`. Its bits 31:20 give the total structure length in bytes, counting every header.
- R2: The entry count is floor((length − 12) / 8), or zero when the length is below 12. Trailing bytes that do not fill an entry are ignored, and no read is issued at or beyond `base_addr + 12 + 8*count`.
- R3: Entry k occupies `base_addr + 12 + 8k` (low dword) and `+4` (high dword). The low dword is read first. The high dword is read only for the matching entry, so a scan that matches entry p makes p+3 reads, and one that matches nothing makes count+1 reads.
- R4: The block identifier is bits 15:8 of the low dword, and the value 3 marks a memory device. The first such entry ends the scan, even when later entries also carry 3.
- R5: `bar_idx` is bits 2:0 of the matching low dword.
- R6: `blk_offset` is {high dword, low dword bits 31:16, 16 zero bits}.
- R7: When no entry matches, `done` pulses with `found`=0 and `range_err`=0.
- R8: `range_err` is 1 exactly when the length supplied for the selected BAR (`bar_len_flat` slice `[64*b +: 64]`) is smaller than `blk_offset`. An equal length is not an error.
- R9: `cfg_rd_req` stays high with a stable `cfg_rd_addr` until `cfg_rd_ack`, and it is low whenever the block is idle.
- R10: `done` lasts one cycle. The results hold until the next accepted `start`, and a `start` pulse during a scan has no effect.
- R11: After reset `busy`, `done`, `found`, `range_err` and `cfg_rd_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (taken only when idle) |
| base_addr | input | CFG_AW | Byte address of the structure start |
| cfg_rd_req | output | 1 | Read request, held until acknowledged |
| cfg_rd_addr | output | CFG_AW | Byte address of the requested dword |
| cfg_rd_ack | input | 1 | Read data valid for the pending request |
| cfg_rd_data | input | 32 | Read data |
| bar_len_flat | input | 8*64 | Length of each BAR, BAR b at bits [64*b +: 64] |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle scan completion pulse |
| found | output | 1 | A memory-device entry was located |
| bar_idx | output | 3 | BAR index of the located entry |
| blk_offset | output | 64 | Offset of the located block within its BAR |
| range_err | output | 1 | Selected BAR length smaller than the offset |

## Verification
A wrong entry count or entry index shows up at the read port within one read. Either an address lands on the trap entry placed just past the structure, or the read count differs from p+3 or count+1. A wrong count can also produce a false `found` on that trap at the `done` pulse. A stale low-dword register or a misdecoded field shows up only at `done`, as a wrong `bar_idx`, `blk_offset` or `range_err`, so every scan compares all three against values the bench recomputes from the structure it built.

// File: rtl/regloc_pkg.sv
package regloc_pkg;
  localparam int DW          = 32;
  localparam int LEN_W       = 12;
  localparam int ID_W        = 8;
  localparam int BIR_W       = 3;
  localparam int OFF_W       = 64;
  localparam int ENTRY_SHIFT = 3;
  localparam int IDX_W       = LEN_W - ENTRY_SHIFT;
  localparam int HDR1_BYTE   = 4;
  localparam int FIRST_BYTE  = 12;
  localparam logic [ID_W-1:0] MEMDEV_ID = 8'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_LO, ST_HI} scan_st_t;

  // total structure length in bytes, from header dword 1
  function automatic logic [LEN_W-1:0] struct_len(input logic [DW-1:0] hdr1);
    return hdr1[31:20];
  endfunction

  // whole 8-byte entries after the 12-byte header area
  function automatic logic [IDX_W-1:0] entry_total(input logic [LEN_W-1:0] len);
    logic [LEN_W-1:0] body;
    if (len < LEN_W'(FIRST_BYTE)) return '0;
    body = len - LEN_W'(FIRST_BYTE);
    return body[LEN_W-1:ENTRY_SHIFT];
  endfunction

  function automatic logic [ID_W-1:0] blk_id(input logic [DW-1:0] lo);
    return lo[15:8];
  endfunction

  function automatic logic [BIR_W-1:0] bar_sel(input logic [DW-1:0] lo);
    return lo[BIR_W-1:0];
  endfunction

  function automatic logic [OFF_W-1:0] blk_off(input logic [DW-1:0] lo,
                                               input logic [DW-1:0] hi);
    return {hi, lo[31:16], 16'h0000};
  endfunction
endpackage

// File: rtl/regloc_addr_gen.sv
module regloc_addr_gen
  import regloc_pkg::*;
#(
  parameter int CFG_AW = 12
) (
  input  scan_st_t          st,
  input  logic [CFG_AW-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  output logic [CFG_AW-1:0] addr
);
  logic [CFG_AW-1:0] entry_base;

  assign entry_base = base + CFG_AW'(FIRST_BYTE) + (CFG_AW'(idx) << ENTRY_SHIFT);

  always_comb begin
    case (st)
      ST_HDR:  addr = base + CFG_AW'(HDR1_BYTE);
      ST_LO:   addr = entry_base;
      ST_HI:   addr = entry_base + CFG_AW'(4);
      default: addr = base;
    endcase
  end
endmodule

// File: rtl/regloc_entry_dec.sv
module regloc_entry_dec
  import regloc_pkg::*;
(
  input  logic [DW-1:0]    lo,
  input  logic [DW-1:0]    hi,
  output logic [BIR_W-1:0] bar,
  output logic [OFF_W-1:0] off
);
  assign bar = bar_sel(lo);
  assign off = blk_off(lo, hi);
endmodule

// File: rtl/regloc_bar_check.sv
module regloc_bar_check
  import regloc_pkg::*;
#(
  parameter int BAR_CNT = 1 << BIR_W
) (
  input  logic [BAR_CNT*OFF_W-1:0] bar_len_flat,
  input  logic [BIR_W-1:0]         bar,
  input  logic [OFF_W-1:0]         off,
  output logic                     too_small
);
  logic [OFF_W-1:0] lens [BAR_CNT];

  generate
    for (genvar g = 0; g < BAR_CNT; g++) begin : g_unpack
      assign lens[g] = bar_len_flat[g*OFF_W +: OFF_W];
    end
  endgenerate

  assign too_small = lens[bar] < off;
endmodule

// File: rtl/regloc_scan.sv
module regloc_scan
  import regloc_pkg::*;
#(
  parameter int CFG_AW = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [CFG_AW-1:0]          base_addr,
  output logic                       cfg_rd_req,
  output logic [CFG_AW-1:0]          cfg_rd_addr,
  input  logic                       cfg_rd_ack,
  input  logic [DW-1:0]              cfg_rd_data,
  input  logic [(1<<BIR_W)*OFF_W-1:0] bar_len_flat,
  output logic                       busy,
  output logic                       done,
  output logic                       found,
  output logic [BIR_W-1:0]           bar_idx,
  output logic [OFF_W-1:0]           blk_offset,
  output logic                       range_err
);
  localparam int BAR_CNT = 1 << BIR_W;

  scan_st_t          st;
  logic [CFG_AW-1:0] base_q;
  logic [IDX_W-1:0]  idx, n_ent;
  logic [DW-1:0]     lo_q;

  // named events for the checker
  logic             hdr_accept, lo_accept, hi_accept;
  logic             lo_match, last_entry;
  logic [IDX_W-1:0] hdr_count;
  logic [BIR_W-1:0] dec_bar;
  logic [OFF_W-1:0] dec_off;
  logic             dec_short;

  assign hdr_accept = (st == ST_HDR) && cfg_rd_ack;
  assign lo_accept  = (st == ST_LO)  && cfg_rd_ack;
  assign hi_accept  = (st == ST_HI)  && cfg_rd_ack;
  assign hdr_count  = entry_total(struct_len(cfg_rd_data));
  assign lo_match   = blk_id(cfg_rd_data) == MEMDEV_ID;
  assign last_entry = ({1'b0, idx} + 1'b1) == {1'b0, n_ent};

  assign busy       = st != ST_IDLE;
  assign cfg_rd_req = busy;

  regloc_addr_gen #(.CFG_AW(CFG_AW)) addr_i (
    .st(st), .base(base_q), .idx(idx), .addr(cfg_rd_addr)
  );

  regloc_entry_dec dec_i (
    .lo(lo_q), .hi(cfg_rd_data), .bar(dec_bar), .off(dec_off)
  );

  regloc_bar_check #(.BAR_CNT(BAR_CNT)) chk_len_i (
    .bar_len_flat(bar_len_flat), .bar(dec_bar), .off(dec_off), .too_small(dec_short)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      base_q     <= '0;
      idx        <= '0;
      n_ent      <= '0;
      lo_q       <= '0;
      done       <= 1'b0;
      found      <= 1'b0;
      bar_idx    <= '0;
      blk_offset <= '0;
      range_err  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          base_q     <= base_addr;
          found      <= 1'b0;
          range_err  <= 1'b0;
          bar_idx    <= '0;
          blk_offset <= '0;
          st         <= ST_HDR;
        end
        ST_HDR: if (hdr_accept) begin
          n_ent <= hdr_count;
          idx   <= '0;
          if (hdr_count == '0) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            st <= ST_LO;
          end
        end
        ST_LO: if (lo_accept) begin
          lo_q <= cfg_rd_data;
          if (lo_match) begin
            st <= ST_HI;
          end else if (last_entry) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_HI: if (hi_accept) begin
          found      <= 1'b1;
          bar_idx    <= dec_bar;
          blk_offset <= dec_off;
          range_err  <= dec_short;
          done       <= 1'b1;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regloc_scan_chk.sv
module regloc_scan_chk #(
  parameter int CFG_AW = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_rd_req,
  input logic [CFG_AW-1:0] cfg_rd_addr,
  input logic              cfg_rd_ack,
  input logic              busy,
  input logic              done,
  input logic              found,
  input logic              range_err,
  input logic              hi_accept
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_req && !cfg_rd_ack |=> cfg_rd_req && $stable(cfg_rd_addr));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cfg_rd_req);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !found |-> !range_err);
  // R6
  hit_after_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && found |-> $past(hi_accept));
endmodule

bind regloc_scan regloc_scan_chk #(.CFG_AW(CFG_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_rd_req(cfg_rd_req), .cfg_rd_addr(cfg_rd_addr),
  .cfg_rd_ack(cfg_rd_ack), .busy(busy), .done(done), .found(found),
  .range_err(range_err), .hi_accept(hi_accept)
);

// File: tb/regloc_scan_tb.sv
module regloc_scan_tb_top;
  localparam int AW = 12;

  logic          clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] base_addr = '0;
  logic          cfg_rd_req, cfg_rd_ack = 0;
  logic [AW-1:0] cfg_rd_addr;
  logic [31:0]   cfg_rd_data = '0;
  logic [511:0]  bar_len_flat = '1;
  logic          busy, done, found, range_err;
  logic [2:0]    bar_idx;
  logic [63:0]   blk_offset;

  int n_chk = 0, n_err = 0;
  logic [31:0] mem [0:1023];
  int lat = 0, wcnt = 0, rd_cnt = 0;
  logic [AW:0] rd_limit = '0;
  logic [AW-1:0] hdr_addr = '0;
  bit bad_read = 0;

  always #4 clk = ~clk;

  regloc_scan #(.CFG_AW(AW)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // read responder
  initial forever begin
    @(negedge clk);
    if (cfg_rd_ack) cfg_rd_ack = 0;
    else if (cfg_rd_req) begin
      if (wcnt >= lat) begin
        cfg_rd_ack  = 1;
        cfg_rd_data = mem[cfg_rd_addr >> 2];
        rd_cnt++;
        if (cfg_rd_addr != hdr_addr && {1'b0, cfg_rd_addr} >= rd_limit) bad_read = 1;
        wcnt = 0;
      end else wcnt++;
    end
  end

  task automatic run_scan(input int len, input int p);
    int n, base, mode;
    bit exp_found, exp_err, inject;
    logic [31:0] lo, hi, lo_p, hi_p;
    logic [63:0] exp_off;
    logic [2:0] exp_bar;
    logic [63:0] s_off;
    logic s_found;
    int waited;
    base = 'h100 + (len % 4) * 'h200;
    n = (len < 12) ? 0 : (len - 12) / 8;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    mem[base >> 2] = 32'hA5C3_0023;
    mem[(base + 4) >> 2] = {len[11:0], 4'hA, 16'h5C3B};
    lo_p = '0; hi_p = '0;
    for (int k = 0; k < n; k++) begin
      logic [7:0] id;
      id = (k == p || k == p + 2) ? 8'd3 : 8'(k % 3);
      lo = {16'(k * 16'h1357 + 16'h2468 + len), id, 5'(k + 3), 3'(k + len)};
      hi = 32'(k * 32'h0101_0101) ^ {len[11:0], 20'h0} ^ 32'h11;
      mem[(base + 12 + 8 * k) >> 2] = lo;
      mem[(base + 16 + 8 * k) >> 2] = hi;
      if (k == p) begin lo_p = lo; hi_p = hi; end
    end
    // trap entry just past the end
    mem[(base + 12 + 8 * n) >> 2] = 32'hBEEF_0306;
    mem[(base + 16 + 8 * n) >> 2] = 32'hDEAD_0001;
    exp_found = p < n;
    exp_off = exp_found ? {hi_p, lo_p[31:16], 16'h0} : 64'h0;
    exp_bar = exp_found ? lo_p[2:0] : 3'd0;
    mode = (len + p) % 3;
    bar_len_flat = '1;
    exp_err = 0;
    if (exp_found) begin
      case (mode)
        0: bar_len_flat[exp_bar*64 +: 64] = exp_off;
        1: begin bar_len_flat[exp_bar*64 +: 64] = exp_off - 1; exp_err = 1; end
        default: bar_len_flat[exp_bar*64 +: 64] = exp_off + 64'h1000;
      endcase
    end
    lat = (len + p) % 3;
    hdr_addr = AW'(base + 4);
    rd_limit = (AW+1)'(base + 12 + 8 * n);
    bad_read = 0; rd_cnt = 0; wcnt = 0;
    inject = (len % 5) == 0;
    base_addr = AW'(base);
    start = 1;
    @(negedge clk);
    start = 0;
    base_addr = AW'(base + 'h40);  // changing base after launch must not matter
    waited = 0;
    while (!done && waited < 3000) begin
      @(negedge clk);
      start = 0;
      waited++;
      if (!done && waited == 2 && inject && busy) start = 1;  // R10 start during scan
    end
    start = 0;
    chk(done, "R10 done seen", {63'b0, done}, 64'h1);
    chk(found == exp_found, "R4 found", {63'b0, found}, {63'b0, exp_found});
    if (exp_found) begin
      chk(bar_idx == exp_bar, "R5 bar_idx", {61'b0, bar_idx}, {61'b0, exp_bar});
      chk(blk_offset == exp_off, "R6 blk_offset", blk_offset, exp_off);
      chk(range_err == exp_err, "R8 range_err", {63'b0, range_err}, {63'b0, exp_err});
    end else begin
      chk(!range_err, "R7 range_err on miss", {63'b0, range_err}, 64'h0);
    end
    chk(!bad_read, "R2 read past end", {63'b0, bad_read}, 64'h0);
    chk(rd_cnt == (exp_found ? p + 3 : n + 1), "R3 read count",
        64'(rd_cnt), 64'(exp_found ? p + 3 : n + 1));
    s_off = blk_offset; s_found = found;
    @(negedge clk);
    chk(!done, "R10 done one cycle", {63'b0, done}, 64'h0);
    @(negedge clk);
    chk(found == s_found && blk_offset == s_off && !busy, "R10 results hold",
        blk_offset, s_off);
    chk(!cfg_rd_req, "R9 idle no request", {63'b0, cfg_rd_req}, 64'h0);
  endtask

  initial begin
    #(8 * 190000);
    n_err++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !found && !range_err && !cfg_rd_req, "R11 reset state",
        {59'b0, busy, done, found, range_err, cfg_rd_req}, 64'h0);
    rst_n = 1;
    @(negedge clk);
    // R1 R2 sweep: every length 0..0x40 including fractional tails, match positions 0..6
    for (int len = 0; len <= 'h40; len++)
      for (int p = 0; p <= 6; p++)
        run_scan(len, p);
    finish_up();
  end
endmodule